// File: doc/BRIEF.md
# Dual-Result Integer ALU with Condition Register

This block is the integer arithmetic and logic stage of a fixed-point signal-processing datapath. Each cycle it accepts two signed operands, a carry-in bit and an 8-bit operation code. One clock edge later it presents a primary result, a secondary result and a one-bit condition register. The secondary result lets a sum and a difference of the same operand pair leave the unit in a single cycle, as butterfly-style kernels need.

Compare operations write the condition register and nothing else. Later select and boolean-constant operations read that register, so a compare followed by a select forms a branch-free conditional move. Operation codes are matched against patterns that contain don't-care bits. A code that fits no pattern produces zero on both results and leaves the condition untouched.

Top module: `dsp_dual_alu`

## Requirements
- R1: All three outputs are registered, and each result appears on the clock edge after its operands and code are presented. A synchronous active-high reset clears res_pri, res_sec and cond_flag to zero.
- R2: Code 1111xxxx gives res_pri = A+B. Code 1010xxxx gives res_pri = A-B+Cin. Code 01010000 gives res_pri = B-A. All arithmetic wraps modulo 2^W.
- R3: Code 001100xx gives res_pri = A+B and res_sec = A-B. Code 001000xx gives res_pri = A+B and res_sec = B-A.
- R4: Compares are signed two's complement and write cond_flag. Code 00111100 writes (A<=B), code 00111000 writes (A<B) and code 001101xx writes (A==B). On a compare, both results are zero.
- R5: cond_flag changes only on a compare code or on reset. Every other code leaves it unchanged.
- R6: Code 00101010 gives res_pri = |B| and code 00101011 gives res_pri = |A|. The most negative value maps to itself.
- R7: Code 00011111 gives A if cond_flag is 1 and B otherwise. Code 00011110 gives B if cond_flag is 1 and A otherwise. The value of cond_flag used is the one held before the current edge.
- R8: Code 00011011 gives 0 if cond_flag is 1 and the value 1 otherwise. Code 00011010 gives 1 if cond_flag is 1 and 0 otherwise.
- R9: Code 0001110x gives all ones. Codes 0001100x and 00000000 give zero. Code 000101xx passes A and code 000100xx passes B.
- R10: Code 000011xx gives A OR B, code 000010xx gives A AND B and code 000001xx gives A XOR B.
- R11: A code that fits none of the patterns in R2 to R10 gives zero on both results and leaves cond_flag unchanged.
- R12: res_sec is zero for every code except the two pair codes of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | W | Operand A, two's complement |
| op_b | input | W | Operand B, two's complement |
| carry_in | input | 1 | Carry added by the subtract-with-carry code |
| opcode | input | 8 | Operation code |
| res_pri | output | W | Registered primary result |
| res_sec | output | W | Registered secondary result |
| cond_flag | output | 1 | Registered condition from the last compare |

## Verification
The bench builds the unit with W = 8 rather than the default 16. At that width the overflow corners are easy to reach with directed operands and come up often under random stimulus: the sum wrapping at +127, the absolute value of -128, and signed-versus-unsigned disagreement in the compares. The random phase draws codes from the whole 256-value space, so the don't-care bit fields and the unmatched codes are both exercised. Compare, select and unmatched codes are interleaved so that the condition register is read on the cycle right after it is written.

// File: rtl/dalu_pkg.sv
package dalu_pkg;

    localparam int OPC_W = 8;

    typedef enum logic [4:0] {
        OP_NONE,
        OP_ADD,
        OP_SUBC,
        OP_RSUB,
        OP_PAIR_FWD,
        OP_PAIR_REV,
        OP_CMP_LE,
        OP_CMP_LT,
        OP_CMP_EQ,
        OP_ABS_A,
        OP_ABS_B,
        OP_SEL_A,
        OP_SEL_B,
        OP_FLAG_INV,
        OP_FLAG_DIR,
        OP_ONES,
        OP_ZERO,
        OP_PASS_A,
        OP_PASS_B,
        OP_OR,
        OP_AND,
        OP_XOR
    } alu_op_e;

    typedef struct packed {
        alu_op_e op;
        logic    is_cmp;
    } alu_dec_t;

    // Pattern match with don't-care fields; every pattern is disjoint.
    function automatic alu_op_e match_opcode(input logic [OPC_W-1:0] c);
        alu_op_e r;
        r = OP_NONE;
        unique casez (c)
            8'b1111_????: r = OP_ADD;
            8'b1010_????: r = OP_SUBC;
            8'b0101_0000: r = OP_RSUB;
            8'b0011_00??: r = OP_PAIR_FWD;
            8'b0010_00??: r = OP_PAIR_REV;
            8'b0011_1100: r = OP_CMP_LE;
            8'b0011_1000: r = OP_CMP_LT;
            8'b0011_01??: r = OP_CMP_EQ;
            8'b0010_1011: r = OP_ABS_A;
            8'b0010_1010: r = OP_ABS_B;
            8'b0001_1111: r = OP_SEL_A;
            8'b0001_1110: r = OP_SEL_B;
            8'b0001_1011: r = OP_FLAG_INV;
            8'b0001_1010: r = OP_FLAG_DIR;
            8'b0001_110?: r = OP_ONES;
            8'b0001_100?: r = OP_ZERO;
            8'b0000_0000: r = OP_ZERO;
            8'b0001_01??: r = OP_PASS_A;
            8'b0001_00??: r = OP_PASS_B;
            8'b0000_11??: r = OP_OR;
            8'b0000_10??: r = OP_AND;
            8'b0000_01??: r = OP_XOR;
            default:      r = OP_NONE;
        endcase
        return r;
    endfunction

    function automatic logic op_is_compare(input alu_op_e op);
        return (op == OP_CMP_LE) || (op == OP_CMP_LT) || (op == OP_CMP_EQ);
    endfunction

endpackage

// File: rtl/dalu_decode.sv
module dalu_decode
    import dalu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output alu_dec_t         dec
);
    alu_op_e op_sel;

    always_comb begin
        op_sel     = match_opcode(opcode);
        dec.op     = op_sel;
        dec.is_cmp = op_is_compare(op_sel);
    end
endmodule

// File: rtl/dalu_arith.sv
module dalu_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum_ab,
    output logic [W-1:0] dif_ab,
    output logic [W-1:0] dif_ba,
    output logic [W-1:0] subc_ab,
    output logic [W-1:0] abs_a,
    output logic [W-1:0] abs_b,
    output logic         lt_ab,
    output logic         eq_ab
);
    localparam int XW = W + 1;

    logic [XW-1:0] dif_ext;

    always_comb begin
        sum_ab  = a + b;
        dif_ext = {a[W-1], a} - {b[W-1], b};
        dif_ab  = dif_ext[W-1:0];
        dif_ba  = b - a;
        subc_ab = dif_ext[W-1:0] + {{(W-1){1'b0}}, cin};
        abs_a   = a[W-1] ? (~a + 1'b1) : a;
        abs_b   = b[W-1] ? (~b + 1'b1) : b;
        lt_ab   = dif_ext[XW-1];
        eq_ab   = (a == b);
    end
endmodule

// File: rtl/dalu_result_mux.sv
module dalu_result_mux
    import dalu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_dec_t     dec,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] sum_ab,
    input  logic [W-1:0] dif_ab,
    input  logic [W-1:0] dif_ba,
    input  logic [W-1:0] subc_ab,
    input  logic [W-1:0] abs_a,
    input  logic [W-1:0] abs_b,
    input  logic         lt_ab,
    input  logic         eq_ab,
    input  logic         cond_q,
    output logic [W-1:0] pri_d,
    output logic [W-1:0] sec_d,
    output logic         cond_d,
    output logic         cond_we
);
    localparam logic [W-1:0] ONE_V  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ONES_V = {W{1'b1}};

    always_comb begin
        pri_d   = '0;
        sec_d   = '0;
        cond_d  = cond_q;
        cond_we = dec.is_cmp;
        unique case (dec.op)
            OP_ADD:      pri_d = sum_ab;
            OP_SUBC:     pri_d = subc_ab;
            OP_RSUB:     pri_d = dif_ba;
            OP_PAIR_FWD: begin
                pri_d = sum_ab;
                sec_d = dif_ab;
            end
            OP_PAIR_REV: begin
                pri_d = sum_ab;
                sec_d = dif_ba;
            end
            OP_CMP_LE:   cond_d = lt_ab | eq_ab;
            OP_CMP_LT:   cond_d = lt_ab;
            OP_CMP_EQ:   cond_d = eq_ab;
            OP_ABS_A:    pri_d = abs_a;
            OP_ABS_B:    pri_d = abs_b;
            OP_SEL_A:    pri_d = cond_q ? a : b;
            OP_SEL_B:    pri_d = cond_q ? b : a;
            OP_FLAG_INV: pri_d = cond_q ? '0 : ONE_V;
            OP_FLAG_DIR: pri_d = cond_q ? ONE_V : '0;
            OP_ONES:     pri_d = ONES_V;
            OP_ZERO:     pri_d = '0;
            OP_PASS_A:   pri_d = a;
            OP_PASS_B:   pri_d = b;
            OP_OR:       pri_d = a | b;
            OP_AND:      pri_d = a & b;
            OP_XOR:      pri_d = a ^ b;
            default:     pri_d = '0;
        endcase
    end
endmodule

// File: rtl/dalu_out_reg.sv
module dalu_out_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pri_d,
    input  logic [W-1:0] sec_d,
    input  logic         cond_d,
    input  logic         cond_we,
    output logic [W-1:0] pri_q,
    output logic [W-1:0] sec_q,
    output logic         cond_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pri_q  <= '0;
            sec_q  <= '0;
            cond_q <= 1'b0;
        end else begin
            pri_q <= pri_d;
            sec_q <= sec_d;
            if (cond_we) begin
                cond_q <= cond_d;
            end
        end
    end
endmodule

// File: rtl/dsp_dual_alu.sv
module dsp_dual_alu
    import dalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    input  logic [7:0]   opcode,
    output logic [W-1:0] res_pri,
    output logic [W-1:0] res_sec,
    output logic         cond_flag
);
    alu_dec_t     dec;
    logic [W-1:0] sum_ab, dif_ab, dif_ba, subc_ab, abs_a, abs_b;
    logic         lt_ab, eq_ab;
    logic [W-1:0] pri_d, sec_d;
    logic         cond_d, cond_we;

    dalu_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    dalu_arith #(.W(W)) u_arith (
        .a       (op_a),
        .b       (op_b),
        .cin     (carry_in),
        .sum_ab  (sum_ab),
        .dif_ab  (dif_ab),
        .dif_ba  (dif_ba),
        .subc_ab (subc_ab),
        .abs_a   (abs_a),
        .abs_b   (abs_b),
        .lt_ab   (lt_ab),
        .eq_ab   (eq_ab)
    );

    dalu_result_mux #(.W(W)) u_mux (
        .dec     (dec),
        .a       (op_a),
        .b       (op_b),
        .sum_ab  (sum_ab),
        .dif_ab  (dif_ab),
        .dif_ba  (dif_ba),
        .subc_ab (subc_ab),
        .abs_a   (abs_a),
        .abs_b   (abs_b),
        .lt_ab   (lt_ab),
        .eq_ab   (eq_ab),
        .cond_q  (cond_flag),
        .pri_d   (pri_d),
        .sec_d   (sec_d),
        .cond_d  (cond_d),
        .cond_we (cond_we)
    );

    dalu_out_reg #(.W(W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .pri_d   (pri_d),
        .sec_d   (sec_d),
        .cond_d  (cond_d),
        .cond_we (cond_we),
        .pri_q   (res_pri),
        .sec_q   (res_sec),
        .cond_q  (cond_flag)
    );
endmodule

// File: rtl/dsp_dual_alu_chk.sv
module dsp_dual_alu_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         carry_in,
    input logic [7:0]   opcode,
    input logic [W-1:0] res_pri,
    input logic [W-1:0] res_sec,
    input logic         cond_flag
);
    logic cmp_code, pair_code;

    always_comb begin
        cmp_code  = (opcode == 8'h3C) || (opcode == 8'h38) || (opcode[7:2] == 6'b001101);
        pair_code = (opcode[7:2] == 6'b001100) || (opcode[7:2] == 6'b001000);
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (res_pri == '0 && res_sec == '0 && !cond_flag)); // R1

    AST_ADD_NEXT: assert property (@(posedge clk) disable iff (rst)
        (opcode[7:4] == 4'hF) |=> (res_pri == $past(op_a + op_b))); // R2

    AST_SUBC_NEXT: assert property (@(posedge clk) disable iff (rst)
        (opcode[7:4] == 4'hA) |=>
            (res_pri == $past(op_a - op_b + {{(W-1){1'b0}}, carry_in}))); // R2

    AST_PAIR_FWD: assert property (@(posedge clk) disable iff (rst)
        (opcode[7:2] == 6'b001100) |=> (res_sec == $past(op_a - op_b))); // R3

    AST_EQ_COND: assert property (@(posedge clk) disable iff (rst)
        (opcode[7:2] == 6'b001101) |=> (cond_flag == $past(op_a == op_b))); // R4

    AST_COND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmp_code |=> $stable(cond_flag)); // R5

    AST_SEL_A: assert property (@(posedge clk) disable iff (rst)
        (opcode == 8'h1F) |=> (res_pri == ($past(cond_flag) ? $past(op_a) : $past(op_b)))); // R7

    AST_SEC_ZERO: assert property (@(posedge clk) disable iff (rst)
        !pair_code |=> (res_sec == '0)); // R12
endmodule

bind dsp_dual_alu dsp_dual_alu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .opcode    (opcode),
    .res_pri   (res_pri),
    .res_sec   (res_sec),
    .cond_flag (cond_flag)
);

// File: tb/sim_dsp_dual_alu.sv
`timescale 1ns/1ps
module sim_dsp_dual_alu;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [7:0]   opcode = 8'h00;
    logic [W-1:0] res_pri;
    logic [W-1:0] res_sec;
    logic         cond_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 0;

    logic [W-1:0] exp_pri;
    logic [W-1:0] exp_sec;
    logic         m_cond = 1'b0;

    always #5 clk = ~clk;

    dsp_dual_alu #(.W(W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .opcode    (opcode),
        .res_pri   (res_pri),
        .res_sec   (res_sec),
        .cond_flag (cond_flag)
    );

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Behavioural model: next-state of results and condition for one cycle.
    task automatic model(input logic r, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic c, input logic [7:0] op, output string tag);
        int sa, sb;
        logic held;
        sa   = $signed(a);
        sb   = $signed(b);
        held = m_cond;
        exp_pri = '0;
        exp_sec = '0;
        tag = "R11";
        if (r) begin
            m_cond = 1'b0;
            tag = "R1";
        end else if (op[7:4] == 4'hF) begin exp_pri = a + b; tag = "R2"; end
        else if (op[7:4] == 4'hA) begin exp_pri = a - b + W'(c); tag = "R2"; end
        else if (op == 8'h50) begin exp_pri = b - a; tag = "R2"; end
        else if (op[7:2] == 6'b001100) begin exp_pri = a + b; exp_sec = a - b; tag = "R3"; end
        else if (op[7:2] == 6'b001000) begin exp_pri = a + b; exp_sec = b - a; tag = "R3"; end
        else if (op == 8'h3C) begin m_cond = (sa <= sb); tag = "R4"; end
        else if (op == 8'h38) begin m_cond = (sa < sb); tag = "R4"; end
        else if (op[7:2] == 6'b001101) begin m_cond = (sa == sb); tag = "R4"; end
        else if (op == 8'h2A) begin exp_pri = W'(sb < 0 ? -sb : sb); tag = "R6"; end
        else if (op == 8'h2B) begin exp_pri = W'(sa < 0 ? -sa : sa); tag = "R6"; end
        else if (op == 8'h1F) begin exp_pri = held ? a : b; tag = "R7"; end
        else if (op == 8'h1E) begin exp_pri = held ? b : a; tag = "R7"; end
        else if (op == 8'h1B) begin exp_pri = held ? W'(0) : W'(1); tag = "R8"; end
        else if (op == 8'h1A) begin exp_pri = held ? W'(1) : W'(0); tag = "R8"; end
        else if (op[7:1] == 7'b0001110) begin exp_pri = '1; tag = "R9"; end
        else if (op[7:1] == 7'b0001100 || op == 8'h00) begin exp_pri = '0; tag = "R9"; end
        else if (op[7:2] == 6'b000101) begin exp_pri = a; tag = "R9"; end
        else if (op[7:2] == 6'b000100) begin exp_pri = b; tag = "R9"; end
        else if (op[7:2] == 6'b000011) begin exp_pri = a | b; tag = "R10"; end
        else if (op[7:2] == 6'b000010) begin exp_pri = a & b; tag = "R10"; end
        else if (op[7:2] == 6'b000001) begin exp_pri = a ^ b; tag = "R10"; end
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(input logic r, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic c, input logic [7:0] op, input string note);
        string tag;
        rst = r; op_a = a; op_b = b; carry_in = c; opcode = op;
        model(r, a, b, c, op, tag);
        @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (res_pri !== exp_pri || res_sec !== exp_sec || cond_flag !== m_cond) begin
            n_fail++;
            $display("FAIL %s %s op=%02h: got pri=%02h sec=%02h cond=%0b, expected pri=%02h sec=%02h cond=%0b",
                     tag, note, op, res_pri, res_sec, cond_flag, exp_pri, exp_sec, m_cond);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        report();
    end

    initial begin
        @(negedge clk);
        // R1: reset clears outputs even with an add presented
        step(1, 8'h11, 8'h22, 1, 8'hF0, "R1 reset");
        step(1, 8'h11, 8'h22, 1, 8'hF0, "R1 reset held");
        // R2: arithmetic with wrap and carry
        step(0, 8'h7F, 8'h01, 0, 8'hF3, "R2 add wrap");
        step(0, 8'h10, 8'h03, 1, 8'hA5, "R2 sub cin=1");
        step(0, 8'h00, 8'h01, 0, 8'hA0, "R2 sub cin=0 wrap");
        step(0, 8'h05, 8'h20, 0, 8'h50, "R2 reverse sub");
        // R3 / R12: pair codes
        step(0, 8'h30, 8'h10, 0, 8'h31, "R3 pair fwd");
        step(0, 8'h30, 8'h10, 0, 8'h23, "R3 pair rev");
        // R4: signed compares
        step(0, 8'hFF, 8'h01, 0, 8'h38, "R4 -1<1 signed");
        step(0, 8'h05, 8'h05, 0, 8'h38, "R4 lt equal");
        step(0, 8'h05, 8'h05, 0, 8'h3C, "R4 le equal");
        step(0, 8'h80, 8'h80, 0, 8'h36, "R4 eq");
        // R5 / R7: cond=1 held through non-compare codes, then read by selects
        step(0, 8'h01, 8'h02, 0, 8'hF0, "R5 hold over add");
        step(0, 8'hAA, 8'h55, 0, 8'h1F, "R7 sel A cond=1");
        step(0, 8'hAA, 8'h55, 0, 8'h1E, "R7 sel B cond=1");
        step(0, 8'h00, 8'h00, 0, 8'h1B, "R8 inv cond=1");
        step(0, 8'h00, 8'h00, 0, 8'h1A, "R8 dir cond=1");
        // R11: unmatched codes keep cond=1 and zero results
        step(0, 8'h12, 8'h34, 1, 8'h01, "R11 unmatched 01");
        step(0, 8'h12, 8'h34, 1, 8'h40, "R11 unmatched 40");
        step(0, 8'h12, 8'h34, 1, 8'h29, "R11 unmatched 29");
        step(0, 8'h12, 8'h34, 1, 8'h1F, "R7 cond still 1");
        // compare clears cond; next cycle select sees it
        step(0, 8'h09, 8'h03, 0, 8'h3C, "R4 9<=3 false");
        step(0, 8'hAA, 8'h55, 0, 8'h1F, "R7 sel A cond=0");
        step(0, 8'hAA, 8'h55, 0, 8'h1E, "R7 sel B cond=0");
        step(0, 8'h00, 8'h00, 0, 8'h1B, "R8 inv cond=0");
        step(0, 8'h00, 8'h00, 0, 8'h1A, "R8 dir cond=0");
        // R6: absolute value
        step(0, 8'hFB, 8'h80, 0, 8'h2B, "R6 abs A=-5");
        step(0, 8'hFB, 8'h80, 0, 8'h2A, "R6 abs B=-128");
        // R9: constants and pass
        step(0, 8'h3C, 8'hC3, 0, 8'h1C, "R9 ones");
        step(0, 8'h3C, 8'hC3, 0, 8'h19, "R9 zero");
        step(0, 8'h3C, 8'hC3, 0, 8'h00, "R9 zero 00");
        step(0, 8'h3C, 8'hC3, 0, 8'h16, "R9 pass A");
        step(0, 8'h3C, 8'hC3, 0, 8'h12, "R9 pass B");
        // R10: logic
        step(0, 8'hF0, 8'h3C, 0, 8'h0E, "R10 or");
        step(0, 8'hF0, 8'h3C, 0, 8'h09, "R10 and");
        step(0, 8'hF0, 8'h3C, 0, 8'h07, "R10 xor");
        // R1: reset mid-run clears a set cond
        step(0, 8'h04, 8'h04, 0, 8'h34, "R4 set cond");
        step(1, 8'h04, 8'h04, 0, 8'hF0, "R1 reset mid-run");
        step(0, 8'hAA, 8'h55, 0, 8'h1F, "R7 after reset");
        // Random phase over the full code space
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 200) == 0, W'($urandom), W'($urandom), 1'($urandom),
                 8'($urandom), "random");
        end
        report();
    end
endmodule